// File: doc/BRIEF.md
# Handshake Multirate Sample Converter

This block sits between two valid/ready streams and changes their sample rate by a fixed integer factor. A compile-time switch picks one of two behaviours. When upsampling, a single stored sample is presented on the output several times in a row before the block pulls the next sample in. When downsampling, the block absorbs several inputs into one register and then presents only the most recent of them.

Upsampling presents the stored sample before reading a new one, so the output stream runs one input sample behind and starts with copies of the reset value. Downsampling keeps the last sample of each group, not the first. The sample width and the ratio are parameters, with defaults of 16 bits and 5. Input and output samples have the same width. Only one of the two ports is open at any time, so one phase counter and one sample register are enough.

Top module: `rate_converter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored sample becomes zero. In upsampling mode (`INTERP`=1) the block then shows `out_valid`=1 and `in_ready`=0. In downsampling mode (`INTERP`=0) it shows `in_ready`=1 and `out_valid`=0. `out_data` reads zero in both modes.
- R2: In upsampling mode, each stored sample completes exactly `RATIO` output transfers before the block accepts the next input. The first `RATIO` outputs after reset are zero. Output k therefore equals input sample floor(k/`RATIO`)−1, or zero for k < `RATIO`.
- R3: In upsampling mode, `in_ready` is high for exactly one input transfer per group. On the cycle after that transfer, `out_valid` is high.
- R4: In downsampling mode, the block takes `RATIO` input transfers and then offers one output. Output k equals input sample k·`RATIO`+`RATIO`−1.
- R5: In downsampling mode, `in_ready` is high on the cycle after an output transfer.
- R6: Once `out_valid` is high and `out_ready` is low at an edge, `out_valid` stays high and `out_data` is unchanged in the next cycle.
- R7: `in_ready` and `out_valid` are never high in the same cycle.
- R8: `out_data` changes only after an edge with an input transfer (`in_valid` and `in_ready` both high). Input samples offered while `in_ready` is low are not taken. Stalls on either port do not change the output sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts an input sample this cycle |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Sink accepts the output sample |
| out_data | output | DATA_W | Output sample |

## Verification
The embedded assertions check on every cycle:
- that an output waiting for the sink is held and stays stable;
- that the two ports are never open together;
- that the stored sample moves only on an input transfer;
- how the phase changes immediately after a transfer in each mode;
- that the phase counter stays in range.

Whether each group holds exactly the right number of repeats, whether the leading outputs are zeros, and whether the last sample of each group is the one kept can be seen only by comparing whole streams. The bench scenarios do this under different patterns of input and output stalls, and again after a reset in the middle of a stream.

// File: rtl/rc_pkg.sv
// Package rc_pkg
// Shared types for the rate converter: the two phases of the transfer loop.
package rc_pkg;
    typedef enum logic {
        PH_ACQ  = 1'b0,   // input port open
        PH_EMIT = 1'b1    // output port open
    } rc_phase_e;
endpackage

// File: rtl/rc_sample_store.sv
// Module rc_sample_store
// Holds one sample. It loads on request and is cleared by synchronous reset.
// Assumes load is already qualified with a completed input transfer.
module rc_sample_store #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Capture the incoming sample on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/rc_phase_ctrl.sv
// Module rc_phase_ctrl
// Alternates between an acquisition burst of ACQ_LEN input transfers and an
// emission burst of EMIT_LEN output transfers. One counter serves both bursts.
// Assumes both lengths are at least 1 and that each fire is already qualified.
module rc_phase_ctrl
    import rc_pkg::*;
#(
    parameter int ACQ_LEN    = 1,
    parameter int EMIT_LEN   = 5,
    parameter bit START_EMIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acq_fire,
    input  logic emit_fire,
    output logic acq_open,
    output logic emit_open
);
    localparam int MAX_LEN = (ACQ_LEN > EMIT_LEN) ? ACQ_LEN : EMIT_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_LEN - 1);
    localparam logic [CNT_W-1:0] EMIT_LAST = CNT_W'(EMIT_LEN - 1);

    rc_phase_e        phase;
    logic [CNT_W-1:0] cnt;

    // Advance the burst counter and switch phase at the end of each burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= START_EMIT ? PH_EMIT : PH_ACQ;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_ACQ: if (acq_fire) begin
                    if (cnt == ACQ_LAST) begin
                        phase <= PH_EMIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_EMIT: if (emit_fire) begin
                    if (cnt == EMIT_LAST) begin
                        phase <= PH_ACQ;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_ACQ;
            endcase
        end
    end

    // Each port is open only during its own phase.
    always_comb begin
        acq_open  = (phase == PH_ACQ);
        emit_open = (phase == PH_EMIT);
    end

    // The counter never goes past the last position of the current burst (R2, R4).
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_ACQ) ? (cnt <= ACQ_LAST) : (cnt <= EMIT_LAST)));
endmodule

// File: rtl/rate_converter.sv
// Module rate_converter
// Fixed-ratio sample-rate converter between two valid/ready channels.
// INTERP=1: each stored sample is emitted RATIO times, then one input is taken.
// INTERP=0: RATIO inputs are taken into one register, then the last is emitted.
// Assumes RATIO >= 1. Reset is synchronous and active low.
module rate_converter #(
    parameter int DATA_W = 16,
    parameter int RATIO  = 5,
    parameter bit INTERP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int ACQ_LEN  = INTERP ? 1 : RATIO;
    localparam int EMIT_LEN = INTERP ? RATIO : 1;

    logic in_fire, out_fire;

    // Qualify transfers on both ports.
    always_comb begin
        in_fire  = in_valid & in_ready;
        out_fire = out_valid & out_ready;
    end

    rc_phase_ctrl #(
        .ACQ_LEN   (ACQ_LEN),
        .EMIT_LEN  (EMIT_LEN),
        .START_EMIT(INTERP)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_fire (in_fire),
        .emit_fire(out_fire),
        .acq_open (in_ready),
        .emit_open(out_valid)
    );

    rc_sample_store #(.DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .load (in_fire),
        .d    (in_data),
        .q    (out_data)
    );

    // A stalled output is held stable (R6).
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // The two ports are never open together (R7).
    assert_port_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // The stored sample moves only on an input transfer (R8).
    assert_store_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_data));

    generate
        if (INTERP) begin : g_up
            // One input transfer reopens the output port (R3).
            assert_acq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready) |=> (out_valid && !in_ready));
        end else begin : g_down
            // One output transfer reopens the input port (R5).
            assert_emit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_ready) |=> (in_ready && !out_valid));
        end
    endgenerate
endmodule

// File: tb/test_rate_converter.sv
// Directed bench: one upsampling and one downsampling instance are driven side
// by side. Each scenario task compares both output streams against models
// computed from the requirements.
module test_rate_converter;
    localparam int W = 16;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic         in_valid_i = 1'b0, out_ready_i = 1'b0, in_ready_i, out_valid_i;
    logic [W-1:0] in_data_i = '0, out_data_i;
    logic         in_valid_d = 1'b0, out_ready_d = 1'b0, in_ready_d, out_valid_d;
    logic [W-1:0] in_data_d = '0, out_data_d;

    rate_converter #(.DATA_W(W), .RATIO(N), .INTERP(1'b1)) i_rate_converter (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid_i), .in_ready(in_ready_i), .in_data(in_data_i),
        .out_valid(out_valid_i), .out_ready(out_ready_i), .out_data(out_data_i));

    rate_converter #(.DATA_W(W), .RATIO(N), .INTERP(1'b0)) i_rate_converter_dn (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid_d), .in_ready(in_ready_d), .in_data(in_data_d),
        .out_valid(out_valid_d), .out_ready(out_ready_d), .out_data(out_data_d));

    int checks = 0;
    int errors = 0;
    int in_idx_i, oc_i, in_idx_d, oc_d;
    logic         hold_i, hold_d;
    logic [W-1:0] hold_data_i, hold_data_d;

    function automatic logic [W-1:0] smp(input int k);
        return W'(k * 613 + 165);
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reset both instances, then check the reset state (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid_i = 1'b1; in_valid_d = 1'b1; out_ready_i = 1'b1; out_ready_d = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid_i == 1'b1 && in_ready_i == 1'b0, "R1 up flags",
              {14'd0, out_valid_i, in_ready_i}, 16'd2);
        check(out_data_i == '0, "R1 up data", out_data_i, '0);
        check(in_ready_d == 1'b1 && out_valid_d == 1'b0, "R1 down flags",
              {14'd0, out_valid_d, in_ready_d}, 16'd1);
        check(out_data_d == '0, "R1 down data", out_data_d, '0);
        rst_n = 1'b1;
        in_valid_i = 1'b0; in_valid_d = 1'b0; out_ready_i = 1'b0; out_ready_d = 1'b0;
        in_idx_i = 0; oc_i = 0; in_idx_d = 0; oc_d = 0;
        hold_i = 1'b0; hold_d = 1'b0;
    endtask

    // Run both streams with the given valid/ready percentages until each
    // instance has produced nout more outputs (R2, R4, R6, R8).
    task automatic run_stream(input string name, input int nout,
                              input int vpct, input int rpct);
        int tgt_i, tgt_d;
        tgt_i = oc_i + nout;
        tgt_d = oc_d + nout;
        while (oc_i < tgt_i || oc_d < tgt_d) begin
            @(negedge clk);
            in_valid_i  = ($urandom_range(99) < vpct);
            in_data_i   = in_valid_i ? smp(in_idx_i) : W'($urandom);
            out_ready_i = (oc_i < tgt_i) && ($urandom_range(99) < rpct);
            in_valid_d  = ($urandom_range(99) < vpct);
            in_data_d   = in_valid_d ? smp(in_idx_d) : W'($urandom);
            out_ready_d = (oc_d < tgt_d) && ($urandom_range(99) < rpct);
            #1;
            if (hold_i)
                check(out_valid_i && out_data_i == hold_data_i, {"R6 up hold ", name},
                      out_data_i, hold_data_i);
            if (hold_d)
                check(out_valid_d && out_data_d == hold_data_d, {"R6 down hold ", name},
                      out_data_d, hold_data_d);
            check(!(in_ready_i && out_valid_i) && !(in_ready_d && out_valid_d),
                  {"R7 ports ", name}, {12'd0, in_ready_i, out_valid_i, in_ready_d, out_valid_d}, '0);
            if (out_valid_i && out_ready_i) begin
                logic [W-1:0] e;
                e = (oc_i < N) ? '0 : smp(oc_i / N - 1);
                check(out_data_i == e, {"R2 up sample ", name}, out_data_i, e);
                oc_i++;
            end
            if (out_valid_d && out_ready_d) begin
                logic [W-1:0] e;
                e = smp(oc_d * N + N - 1);
                check(out_data_d == e, {"R4 down sample ", name}, out_data_d, e);
                oc_d++;
            end
            hold_i = out_valid_i && !out_ready_i; hold_data_i = out_data_i;
            hold_d = out_valid_d && !out_ready_d; hold_data_d = out_data_d;
            if (in_valid_i && in_ready_i) in_idx_i++;   // R3/R8: only offered-and-open counts
            if (in_valid_d && in_ready_d) in_idx_d++;   // R5/R8
        end
        @(negedge clk);
        in_valid_i = 1'b0; in_valid_d = 1'b0; out_ready_i = 1'b0; out_ready_d = 1'b0;
        hold_i = out_valid_i; hold_data_i = out_data_i;
        hold_d = out_valid_d; hold_data_d = out_data_d;
    endtask

    // Input transfer count per output group in upsampling mode (R3).
    task automatic check_group_inputs();
        check(in_idx_i == (oc_i + N - 1) / N || in_idx_i == oc_i / N,
              "R3 up inputs per group", W'(in_idx_i), W'(oc_i / N));
        check(in_idx_d >= oc_d * N && in_idx_d <= oc_d * N + N,
              "R5 down inputs per output", W'(in_idx_d), W'(oc_d * N));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 progress actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        run_stream("free", 30, 100, 100);
        check_group_inputs();
        run_stream("in_stall", 30, 25, 100);
        check_group_inputs();
        run_stream("out_stall", 30, 100, 20);
        check_group_inputs();
        run_stream("both_stall", 40, 50, 50);
        check_group_inputs();
        run_stream("pre_reset", 7, 60, 60);
        do_reset();
        run_stream("after_reset", 25, 70, 40);
        check_group_inputs();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule